// File: doc/BRIEF.md
# Port-Indexed Calendar Clock

This block is a calendar clock that a host reaches through two byte-wide I/O ports. The host first writes a register number to the select port. It then reads or writes the chosen register through the data port, which sits at the next I/O address. The clock keeps second, minute, hour (0 to 23), day of month, month and a two-digit year. Each field is presented in packed BCD or in plain binary, depending on a mode bit.

A one-pulse-per-second tick starts an update window. For a fixed number of clock cycles a flag in the first status register reads 1. At the end of that window every time field moves forward at once. Software that polls the flag can therefore avoid reading a half-updated time. The block also holds a second status register and a free general-purpose byte, which firmware can use, for example, as a restart code.

Top module: `rtc_index_port`

## Requirements
- R1: A write to I/O address `IDX_PORT` (default 0x70) stores the 8-bit register number, and a read there returns it. The data port is at `IDX_PORT`+1. A write to any other address changes nothing, and a read from any other address returns 0x00.
- R2: After reset the time reads as 00:00:00 on day 01, month 01, year 00. Both status registers and the general byte read 0x00.
- R3: A tick that arrives while no update is running sets status A bit 7 for exactly `UIP_LEAD` clock cycles. All time fields advance by one second on the edge where the bit clears, and they change at no other time except when the host writes them. A tick that arrives while the bit is set is ignored.
- R4: Seconds and minutes wrap from 59 to 0 and carry into the next field. Hours wrap from 23 to 0 and carry into the day.
- R5: The day wraps to 1 after the last day of the month. That is 30 for months 4, 6, 9 and 11, and 31 for the other months. For month 2 it is 29 when the year is a multiple of 4 (00 included) and 28 otherwise. The month wraps from 12 to 1 and carries into the year, and the year wraps from 99 to 00.
- R6: When bit 2 of status B (register 0x0B) is 0, the time fields are read and written as packed BCD, with tens in bits 7:4 and ones in bits 3:0. When the bit is 1, they are read and written as plain binary.
- R7: Register 0x0F reads back the last byte written to it, and status B reads back all eight written bits. Status A (register 0x0A) reads back its bits 6:0 as written. Bit 7 of status A shows the update flag, and a write to that bit has no effect.
- R8: A data-port read at a register number that is not mapped returns 0x00, and a write there changes no register. The mapped numbers are: seconds 0x00, minutes 0x02, hours 0x04, day 0x07, month 0x08, year 0x09, status A 0x0A, status B 0x0B and general byte 0x0F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| io_addr | input | 8 | I/O address of the access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe; `io_rdata` holds the result from the next cycle on |
| io_rdata | output | 8 | Read data, registered |

## Verification
Each time field is a counter that feeds the next one, so a wrong carry or a wrong wrap bound is visible in the very next port read after the single tick that crosses the boundary. The bench therefore loads each boundary time, issues one tick and reads back every field. A fault in the update sequencer shows up in a back-to-back read burst of status A. That burst shows the flag width cycle by cycle and whether a second tick restarted the window. A wrong encoding path shows up as soon as the mode bit flips and the same stored value is read through the port in the other form.

// File: rtl/rtc_pkg.sv
// Shared register numbers, field slots and code conversions for the
// port-indexed calendar clock. Assumes fields never exceed 7 bits.
package rtc_pkg;
    localparam int NF = 6;                     // number of time fields
    typedef logic [6:0] tval_t;                // one binary time field

    localparam logic [2:0] FI_SEC  = 3'd0;
    localparam logic [2:0] FI_MIN  = 3'd1;
    localparam logic [2:0] FI_HOUR = 3'd2;
    localparam logic [2:0] FI_DAY  = 3'd3;
    localparam logic [2:0] FI_MON  = 3'd4;
    localparam logic [2:0] FI_YEAR = 3'd5;

    localparam logic [7:0] RIX_SEC  = 8'h00;
    localparam logic [7:0] RIX_MIN  = 8'h02;
    localparam logic [7:0] RIX_HOUR = 8'h04;
    localparam logic [7:0] RIX_DAY  = 8'h07;
    localparam logic [7:0] RIX_MON  = 8'h08;
    localparam logic [7:0] RIX_YEAR = 8'h09;
    localparam logic [7:0] RIX_STA  = 8'h0A;
    localparam logic [7:0] RIX_STB  = 8'h0B;
    localparam logic [7:0] RIX_GEN  = 8'h0F;

    localparam int STB_BIN = 2;                // status B: 1 = binary fields

    // binary 0..99 to packed BCD
    function automatic logic [7:0] to_bcd(input tval_t v);
        tval_t t;
        tval_t o;
        t = v / 7'd10;
        o = v - t * 7'd10;
        return {t[3:0], o[3:0]};
    endfunction

    // packed BCD to binary
    function automatic tval_t from_bcd(input logic [7:0] b);
        logic [7:0] s;
        s = {4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]};
        return s[6:0];
    endfunction

    // last day of a month; two-digit year divisible by 4 is leap
    function automatic tval_t month_days(input tval_t mon, input tval_t yr);
        case (mon)
            7'd2:                     return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
            default:                  return 7'd31;
        endcase
    endfunction

    // true for a register number that is mapped
    function automatic logic idx_used(input logic [7:0] ix);
        return ix inside {RIX_SEC, RIX_MIN, RIX_HOUR, RIX_DAY, RIX_MON,
                          RIX_YEAR, RIX_STA, RIX_STB, RIX_GEN};
    endfunction
endpackage

// File: rtl/rtc_update_seq.sv
// Update-window sequencer. A tick seen while idle raises the flag for
// UIP_LEAD cycles; the advance pulse fires on the last of them, and the
// flag clears on that same edge. Ticks during the window are dropped.
// Assumes UIP_LEAD >= 1.
module rtc_update_seq #(
    parameter int UIP_LEAD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic uip,
    output logic advance
);
    localparam int CW = $clog2(UIP_LEAD + 1);

    logic          uip_q;
    logic [CW-1:0] cnt_q;

    // open the window on an idle tick, count it down, then close it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uip_q <= 1'b0;
            cnt_q <= '0;
        end else if (!uip_q) begin
            if (tick) begin
                uip_q <= 1'b1;
                cnt_q <= CW'(UIP_LEAD - 1);
            end
        end else if (cnt_q == '0) begin
            uip_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign uip     = uip_q;
    assign advance = uip_q && (cnt_q == '0);
endmodule

// File: rtl/rtc_calendar.sv
// Calendar counter. It holds six binary fields and steps them by one
// second on advance, with calendar carries. A load writes one field
// and takes priority over the step. Assumes loaded values are in range.
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 advance,
    input  logic                 ld_en,
    input  logic [2:0]           ld_field,
    input  tval_t                ld_val,
    output logic [NF-1:0][6:0]   fields
);
    logic [NF-1:0][6:0] f_q;
    logic [NF-1:0][6:0] f_d;

    // next state: one-second step with carry chain, then host load
    always_comb begin
        f_d = f_q;
        if (advance) begin
            if (f_q[FI_SEC] >= 7'd59) begin
                f_d[FI_SEC] = '0;
                if (f_q[FI_MIN] >= 7'd59) begin
                    f_d[FI_MIN] = '0;
                    if (f_q[FI_HOUR] >= 7'd23) begin
                        f_d[FI_HOUR] = '0;
                        if (f_q[FI_DAY] >= month_days(f_q[FI_MON], f_q[FI_YEAR])) begin
                            f_d[FI_DAY] = 7'd1;
                            if (f_q[FI_MON] >= 7'd12) begin
                                f_d[FI_MON]  = 7'd1;
                                f_d[FI_YEAR] = (f_q[FI_YEAR] >= 7'd99) ? 7'd0
                                                                       : f_q[FI_YEAR] + 7'd1;
                            end else begin
                                f_d[FI_MON] = f_q[FI_MON] + 7'd1;
                            end
                        end else begin
                            f_d[FI_DAY] = f_q[FI_DAY] + 7'd1;
                        end
                    end else begin
                        f_d[FI_HOUR] = f_q[FI_HOUR] + 7'd1;
                    end
                end else begin
                    f_d[FI_MIN] = f_q[FI_MIN] + 7'd1;
                end
            end else begin
                f_d[FI_SEC] = f_q[FI_SEC] + 7'd1;
            end
        end
        if (ld_en) begin
            f_d[ld_field] = ld_val;
        end
    end

    // field registers; day and month start at 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NF; i++) begin
                f_q[i] <= (i == int'(FI_DAY) || i == int'(FI_MON)) ? 7'd1 : 7'd0;
            end
        end else begin
            f_q <= f_d;
        end
    end

    assign fields = f_q;
endmodule

// File: rtl/rtc_index_port.sv
// Top of the port-indexed calendar clock. It decodes the select and data
// ports and holds the status registers and the general byte. It converts
// the time fields between binary storage and BCD at the port, and it
// registers read data. Assumes one access per cycle.
module rtc_index_port
    import rtc_pkg::*;
#(
    parameter logic [7:0] IDX_PORT = 8'h70,
    parameter int         UIP_LEAD = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1hz,
    input  logic [7:0] io_addr,
    input  logic       io_wr,
    input  logic [7:0] io_wdata,
    input  logic       io_rd,
    output logic [7:0] io_rdata
);
    localparam logic [7:0] DAT_PORT = IDX_PORT + 8'd1;

    logic [7:0]         idx_q;
    logic [6:0]         sta_q;
    logic [7:0]         stb_q;
    logic [7:0]         gen_q;
    logic [7:0]         rdata_q;
    logic               uip;
    logic               advance;
    logic [NF-1:0][6:0] fields;
    logic               hit_idx;
    logic               hit_dat;
    logic               is_time;
    logic [2:0]         fsel;
    logic               cal_wr;
    tval_t              cal_val;
    tval_t              cur;
    logic [7:0]         rd_val;

    assign hit_idx = (io_addr == IDX_PORT);
    assign hit_dat = (io_addr == DAT_PORT);

    rtc_update_seq #(.UIP_LEAD(UIP_LEAD)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .uip     (uip),
        .advance (advance)
    );

    rtc_calendar cal_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .ld_en    (cal_wr),
        .ld_field (fsel),
        .ld_val   (cal_val),
        .fields   (fields)
    );

    // map the selected register number to a time-field slot
    always_comb begin
        is_time = 1'b1;
        fsel    = FI_SEC;
        case (idx_q)
            RIX_SEC:  fsel = FI_SEC;
            RIX_MIN:  fsel = FI_MIN;
            RIX_HOUR: fsel = FI_HOUR;
            RIX_DAY:  fsel = FI_DAY;
            RIX_MON:  fsel = FI_MON;
            RIX_YEAR: fsel = FI_YEAR;
            default:  is_time = 1'b0;
        endcase
    end

    assign cal_wr  = io_wr && hit_dat && is_time;
    assign cal_val = stb_q[STB_BIN] ? io_wdata[6:0] : from_bcd(io_wdata);
    assign cur     = fields[fsel];

    // read value of the selected register, encoded per status B
    always_comb begin
        rd_val = 8'h00;
        if (is_time) begin
            rd_val = stb_q[STB_BIN] ? {1'b0, cur} : to_bcd(cur);
        end else begin
            case (idx_q)
                RIX_STA: rd_val = {uip, sta_q};
                RIX_STB: rd_val = stb_q;
                RIX_GEN: rd_val = gen_q;
                default: rd_val = 8'h00;
            endcase
        end
    end

    // select register and the host-writable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= 8'h00;
            sta_q <= 7'h00;
            stb_q <= 8'h00;
            gen_q <= 8'h00;
        end else if (io_wr) begin
            if (hit_idx) idx_q <= io_wdata;
            if (hit_dat && idx_q == RIX_STA) sta_q <= io_wdata[6:0];
            if (hit_dat && idx_q == RIX_STB) stb_q <= io_wdata;
            if (hit_dat && idx_q == RIX_GEN) gen_q <= io_wdata;
        end
    end

    // registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= 8'h00;
        end else if (io_rd) begin
            rdata_q <= hit_idx ? idx_q : (hit_dat ? rd_val : 8'h00);
        end
    end

    assign io_rdata = rdata_q;
endmodule

// File: rtl/rtc_index_port_chk.sv
// Property checker for the port-indexed calendar clock, bound to the top.
module rtc_index_port_chk
    import rtc_pkg::*;
#(
    parameter logic [7:0] IDX_PORT = 8'h70,
    parameter int         UIP_LEAD = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               uip,
    input logic               cal_wr,
    input logic [NF-1:0][6:0] fields,
    input logic [7:0]         io_addr,
    input logic               io_rd,
    input logic [7:0]         idx_q,
    input logic [7:0]         io_rdata
);
    int hi_cnt;

    // length of the current flag-high run
    always_ff @(posedge clk) begin
        if (!rst_n)   hi_cnt <= 0;
        else if (uip) hi_cnt <= hi_cnt + 1;
        else          hi_cnt <= 0;
    end

    AST_IDX_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == IDX_PORT) |=> io_rdata == $past(idx_q)); // R1
    AST_UIP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uip) |-> hi_cnt == UIP_LEAD); // R3
    AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!uip && !cal_wr) |=> $stable(fields)); // R3
    AST_STA_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == IDX_PORT + 8'd1 && idx_q == RIX_STA)
        |=> io_rdata[7] == $past(uip)); // R7
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == IDX_PORT + 8'd1 && !idx_used(idx_q))
        |=> io_rdata == 8'h00); // R8
endmodule

bind rtc_index_port rtc_index_port_chk #(
    .IDX_PORT (IDX_PORT),
    .UIP_LEAD (UIP_LEAD)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .uip      (uip),
    .cal_wr   (cal_wr),
    .fields   (fields),
    .io_addr  (io_addr),
    .io_rd    (io_rd),
    .idx_q    (idx_q),
    .io_rdata (io_rdata)
);

// File: tb/rtc_index_port_tb_top.sv
// Scoreboard bench: driver tasks queue expected read data, and a monitor
// pops and compares each result one cycle after its read strobe.
module rtc_index_port_tb_top;
    localparam time CLK_PERIOD = 10;
    localparam int  LEAD       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       io_wr = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic       io_rd = 1'b0;
    logic [7:0] io_rdata;

    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;
    logic       rd_d = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    rtc_index_port #(.IDX_PORT(8'h70), .UIP_LEAD(LEAD)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_1hz (tick),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .io_rd    (io_rd),
        .io_rdata (io_rdata)
    );

    // note which edges captured a read
    always @(posedge clk) rd_d <= io_rd;

    // monitor: compare each captured read with the oldest expectation
    always @(negedge clk) begin
        if (rd_d) begin
            logic [7:0] e;
            string      t;
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL scoreboard: got %02h expected no read", io_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (io_rdata !== e) begin
                    failures++;
                    $display("FAIL %s: got %02h expected %02h", t, io_rdata, e);
                end
            end
        end
    end

    task automatic port_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] ix, input logic [7:0] d);
        port_wr(8'h70, ix);
        port_wr(8'h71, d);
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic reg_chk(input logic [7:0] ix, input logic [7:0] e, input string tag);
        port_wr(8'h70, ix);
        expect_rd(8'h71, e, tag);
    endtask

    task automatic one_sec();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        repeat (LEAD + 2) @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] y, mo, dy, h, mi, s);
        reg_wr(8'h09, y);  reg_wr(8'h08, mo); reg_wr(8'h07, dy);
        reg_wr(8'h04, h);  reg_wr(8'h02, mi); reg_wr(8'h00, s);
    endtask

    task automatic chk_time(input logic [7:0] y, mo, dy, h, mi, s, input string tag);
        reg_chk(8'h09, y, tag);  reg_chk(8'h08, mo, tag); reg_chk(8'h07, dy, tag);
        reg_chk(8'h04, h, tag);  reg_chk(8'h02, mi, tag); reg_chk(8'h00, s, tag);
    endtask

    // back-to-back status A reads across a tick; a second tick lands mid-window
    task automatic uip_burst(input logic [6:0] low);
        port_wr(8'h70, 8'h0A);
        @(negedge clk);
        io_addr = 8'h71; io_rd = 1'b1; tick = 1'b1;
        exp_q.push_back({1'b0, low}); tag_q.push_back("R3 flag before tick");
        for (int j = 1; j <= LEAD + 1; j++) begin
            @(negedge clk);
            tick = (j == 2);
            exp_q.push_back({(j <= LEAD), low});
            tag_q.push_back("R3 flag window");
        end
        @(negedge clk);
        io_rd = 1'b0; tick = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    // stimulus
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        chk_time(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R2 time");
        reg_chk(8'h0A, 8'h00, "R2 status A");
        reg_chk(8'h0B, 8'h00, "R2 status B");
        reg_chk(8'h0F, 8'h00, "R2 general");

        // R1: select port echo, foreign address ignored
        port_wr(8'h70, 8'h09);
        expect_rd(8'h70, 8'h09, "R1 index echo");
        expect_rd(8'h72, 8'h00, "R1 foreign read");
        port_wr(8'h72, 8'h55);
        expect_rd(8'h70, 8'h09, "R1 foreign write");

        // R7: read-back registers and read-only flag bit
        reg_wr(8'h0F, 8'hA5);
        reg_chk(8'h0F, 8'hA5, "R7 general");
        reg_wr(8'h0A, 8'hFF);
        reg_chk(8'h0A, 8'h7F, "R7 status A bit7 ignored");
        reg_wr(8'h0A, 8'h26);
        reg_chk(8'h0A, 8'h26, "R7 status A");
        reg_wr(8'h0B, 8'h83);
        reg_chk(8'h0B, 8'h83, "R7 status B");
        reg_wr(8'h0B, 8'h02);

        // R8: unmapped numbers
        reg_wr(8'h05, 8'h33);
        reg_chk(8'h05, 8'h00, "R8 unmapped 05");
        reg_chk(8'h01, 8'h00, "R8 unmapped 01");
        reg_chk(8'h0F, 8'hA5, "R8 general untouched");
        reg_chk(8'h04, 8'h00, "R8 hours untouched");

        // R3: flag window, ignored second tick, single advance
        uip_burst(7'h26);
        reg_chk(8'h00, 8'h01, "R3 one second");

        // R4: second, minute and hour carries
        set_time(8'h24, 8'h03, 8'h15, 8'h23, 8'h59, 8'h59);
        one_sec();
        chk_time(8'h24, 8'h03, 8'h16, 8'h00, 8'h00, 8'h00, "R4 midnight");
        set_time(8'h24, 8'h03, 8'h16, 8'h10, 8'h59, 8'h59);
        one_sec();
        reg_chk(8'h04, 8'h11, "R4 hour step");
        reg_chk(8'h02, 8'h00, "R4 minute wrap");

        // R5: month lengths, leap years, year wrap
        set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        one_sec();
        chk_time(8'h23, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00, "R5 feb common");
        set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        one_sec();
        reg_chk(8'h07, 8'h29, "R5 feb leap day");
        reg_chk(8'h08, 8'h02, "R5 feb leap month");
        set_time(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59);
        one_sec();
        reg_chk(8'h07, 8'h01, "R5 after leap day");
        reg_chk(8'h08, 8'h03, "R5 after leap month");
        set_time(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        one_sec();
        reg_chk(8'h07, 8'h29, "R5 year 00 leap");
        set_time(8'h05, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
        one_sec();
        reg_chk(8'h07, 8'h01, "R5 30-day month");
        reg_chk(8'h08, 8'h05, "R5 30-day month");
        set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
        one_sec();
        chk_time(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R5 year wrap");

        // R6: binary mode
        reg_wr(8'h0B, 8'h06);
        reg_wr(8'h00, 8'h2D);
        reg_chk(8'h00, 8'h2D, "R6 binary seconds");
        reg_wr(8'h00, 8'h3B);
        reg_wr(8'h02, 8'h3B);
        reg_wr(8'h04, 8'h0A);
        one_sec();
        reg_chk(8'h00, 8'h00, "R6 binary sec wrap");
        reg_chk(8'h02, 8'h00, "R6 binary min wrap");
        reg_chk(8'h04, 8'h0B, "R6 binary hour");
        reg_wr(8'h0B, 8'h02);
        reg_chk(8'h04, 8'h11, "R6 back to BCD");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule